// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a 32-bit virtual address into a physical address. It looks the address up in a single-level page table held in internal storage. The storage holds one table for each process. A base register picks the table that serves lookups, and software changes it when it switches process. Every table entry holds a valid flag, a two-bit rights field and a physical page number. Entries are loaded through a management write port.

A lookup request carries an address and an access kind: instruction fetch, data read or data write. Pages are 4 KiB, so the twelve low address bits pass through unchanged. The virtual page number above them selects an entry in the current table. One cycle after the request, the block returns a strobe and a status. The status says either that the lookup succeeded, with the physical page number joined to the offset, or which kind of fault stopped it. A page that is not present gives one fault code. An access that the page's rights forbid gives another.

Top module: `pt_translator`

## Requirements
- R1: A synchronous active-low reset clears every entry of every table to not-present, sets the table base to 0 and holds rsp_valid low, so any lookup after reset reports a page fault.
- R2: rsp_valid is high in exactly the cycle after a cycle with req_valid high, and low in every other cycle.
- R3: A successful lookup reports status 0 and rsp_paddr = {entry PPN, req_vaddr[11:0]}; the offset bits pass through unchanged.
- R4: If the selected entry's valid flag is 0, the status is 1 (page fault) and rsp_paddr is 0.
- R5: Rights field encoding: 00 allows read only, 01 allows read and write, 10 allows fetch only, 11 allows fetch, read and write. An access the rights forbid on a present page reports status 2 (protection fault) with rsp_paddr 0.
- R6: Access kinds are encoded 00 fetch, 01 read, 10 write. Code 11 is never allowed, so on a present page it reports status 2.
- R7: When a page is both not present and forbidden for the access, the status is 1: the page-fault check has priority.
- R8: Only virtual page numbers below the table size (32) are mapped. Any set bit in req_vaddr[31:17] reports status 1, whatever the entry at the low index holds.
- R9: The table base selects which process table serves lookups. A base write takes effect for requests in the cycle after it, and a request in the same cycle as the write still uses the old base.
- R10: A management write to an entry in the same cycle as a lookup of that entry returns the old entry contents. The next lookup returns the new contents.
- R11: Status code 3 is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 fetch, 01 read, 10 write |
| base_we | input | 1 | Table base write strobe |
| base_sel | input | 2 | New table base (process table number) |
| mt_we | input | 1 | Management entry write strobe |
| mt_table | input | 2 | Table number written |
| mt_idx | input | 5 | Entry index written |
| mt_valid | input | 1 | Valid flag written |
| mt_rights | input | 2 | Rights field written |
| mt_ppn | input | 8 | Physical page number written |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_status | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| rsp_paddr | output | 20 | Physical address, 0 on any fault |

## Verification
The hardest situations to reach from the ports are those that depend on two events landing in the same clock. One is a management write colliding with a lookup of the same entry. The other is a base switch arriving together with a request. The bench drives both in one cycle, checks that the old entry or old table is returned, and then repeats the lookup to see the new one. The rest of the behaviour is covered by a full sweep: every table, every index and every access code, against entries whose valid flag, rights and page number are computed from the table and index. That sweep reaches every pairing of rights and access, both present and absent.

// File: rtl/pt_pkg.sv
// Package: shared types for the page table translator.
// Assumes a 4 KiB page and a single-level table per process.
package pt_pkg;

    localparam int PO_W  = 12;
    localparam int PPN_W = 8;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        RT_RO  = 2'b00,
        RT_RW  = 2'b01,
        RT_X   = 2'b10,
        RT_RWX = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_PAGE  = 2'b01,
        ST_PROT  = 2'b10,
        ST_UNUSED = 2'b11
    } status_e;

    typedef struct packed {
        logic             valid;
        logic [1:0]       rights;
        logic [PPN_W-1:0] ppn;
    } pte_t;

endpackage

// File: rtl/pt_table_mem.sv
// Module: entry storage for all process tables.
// One synchronous write port, one registered read port. A read and a write
// of the same address in one cycle return the old contents.
// Assumes the entry count stays small enough to clear in reset.
module pt_table_mem
    import pt_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  pte_t              wdata,
    input  logic [ADDR_W-1:0] raddr,
    output pte_t              rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    pte_t mem [DEPTH];
    pte_t rd_q;

    // Store writes, clear all entries on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read; sees pre-write contents on a same-cycle collision.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= mem[raddr];
    end

    assign rdata = rd_q;

endmodule

// File: rtl/pt_perm_check.sv
// Module: decides the lookup status from an entry and an access kind.
// Assumes the entry is the one selected for the request. A range error or a
// not-present page outranks a rights violation.
module pt_perm_check
    import pt_pkg::*;
(
    input  pte_t       entry,
    input  logic [1:0] acc,
    input  logic       out_of_range,
    output logic [1:0] status
);
    logic allow;

    // Rights against access kind.
    always_comb begin
        unique case (acc)
            ACC_FETCH: allow = (entry.rights == RT_X)  || (entry.rights == RT_RWX);
            ACC_READ:  allow = (entry.rights != RT_X);
            ACC_WRITE: allow = (entry.rights == RT_RW) || (entry.rights == RT_RWX);
            default:   allow = 1'b0;
        endcase
    end

    // Priority: presence first, then rights.
    always_comb begin
        if (out_of_range || !entry.valid) status = ST_PAGE;
        else if (!allow)                  status = ST_PROT;
        else                              status = ST_OK;
    end

endmodule

// File: rtl/pt_translator.sv
// Module: top of the page table translator.
// Accepts one lookup per cycle and answers one cycle later. The base register
// picks the process table; management writes load entries in any table.
// Assumes the virtual page number space mapped per table is 2**IDX_W pages.
module pt_translator
    import pt_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int IDX_W   = 5,
    parameter int TBL_W   = 2,
    parameter int PPN_WID = PPN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [1:0]            req_acc,
    input  logic                  base_we,
    input  logic [TBL_W-1:0]      base_sel,
    input  logic                  mt_we,
    input  logic [TBL_W-1:0]      mt_table,
    input  logic [IDX_W-1:0]      mt_idx,
    input  logic                  mt_valid,
    input  logic [1:0]            mt_rights,
    input  logic [PPN_WID-1:0]    mt_ppn,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_status,
    output logic [PPN_WID+PO_W-1:0] rsp_paddr
);
    localparam int ADDR_W = TBL_W + IDX_W;
    localparam int HI_LSB = PO_W + IDX_W;
    localparam int PA_W   = PPN_WID + PO_W;

    logic [TBL_W-1:0] base_q;
    logic             req_q;
    logic [1:0]       acc_q;
    logic [PO_W-1:0]  off_q;
    logic             oor_q;
    pte_t             wentry;
    pte_t             rentry;
    logic [1:0]       status;

    // Table base register, changed on a process switch.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_sel;
    end

    // Request stage registers that travel beside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            acc_q <= '0;
            off_q <= '0;
            oor_q <= 1'b0;
        end else begin
            req_q <= req_valid;
            acc_q <= req_acc;
            off_q <= req_vaddr[PO_W-1:0];
            oor_q <= |req_vaddr[VA_W-1:HI_LSB];
        end
    end

    assign wentry.valid  = mt_valid;
    assign wentry.rights = mt_rights;
    assign wentry.ppn    = mt_ppn;

    pt_table_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mt_we),
        .waddr ({mt_table, mt_idx}),
        .wdata (wentry),
        .raddr ({base_q, req_vaddr[HI_LSB-1:PO_W]}),
        .rdata (rentry)
    );

    pt_perm_check u_chk (
        .entry        (rentry),
        .acc          (acc_q),
        .out_of_range (oor_q),
        .status       (status)
    );

    // Response: address only on success.
    always_comb begin
        rsp_valid  = req_q;
        rsp_status = req_q ? status : ST_OK;
        rsp_paddr  = (req_q && status == ST_OK) ? {rentry.ppn, off_q} : '0;
    end

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_status != ST_OK || rsp_paddr[PO_W-1:0] == $past(req_vaddr[PO_W-1:0])));
    // R4
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != ST_OK) |-> (rsp_paddr == {PA_W{1'b0}}));
    // R8
    range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && |req_vaddr[VA_W-1:HI_LSB]) |=> (rsp_status == ST_PAGE));
    // R6
    rsvd_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc == ACC_RSVD) |=> (rsp_status != ST_OK));
    // R11
    no_code3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != ST_UNUSED));

endmodule

// File: tb/sim_pt_translator.sv
module sim_pt_translator;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_acc;
    logic        base_we;
    logic [1:0]  base_sel;
    logic        mt_we;
    logic [1:0]  mt_table;
    logic [4:0]  mt_idx;
    logic        mt_valid;
    logic [1:0]  mt_rights;
    logic [7:0]  mt_ppn;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [19:0] rsp_paddr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pt_translator u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .base_we(base_we), .base_sel(base_sel), .mt_we(mt_we),
        .mt_table(mt_table), .mt_idx(mt_idx), .mt_valid(mt_valid),
        .mt_rights(mt_rights), .mt_ppn(mt_ppn), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_paddr(rsp_paddr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit ent_valid(input int t, input int i);
        return ((t + i) % 5) != 0;
    endfunction
    function automatic logic [1:0] ent_rights(input int t, input int i);
        return 2'((t + i) % 4);
    endfunction
    function automatic logic [7:0] ent_ppn(input int t, input int i);
        return 8'((t * 37 + i * 3 + 1) & 255);
    endfunction
    function automatic bit allowed(input logic [1:0] r, input logic [1:0] a);
        case (a)
            2'd0: return (r == 2'd2) || (r == 2'd3);
            2'd1: return r != 2'd2;
            2'd2: return (r == 2'd1) || (r == 2'd3);
            default: return 1'b0;
        endcase
    endfunction

    // Starts and ends at a negedge.
    task automatic wr_entry(input int t, input int i, input bit v, input logic [1:0] r, input logic [7:0] p);
        mt_we = 1'b1; mt_table = 2'(t); mt_idx = 5'(i);
        mt_valid = v; mt_rights = r; mt_ppn = p;
        @(negedge clk);
        mt_we = 1'b0;
    endtask

    task automatic set_base(input int t);
        base_we = 1'b1; base_sel = 2'(t);
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] a,
                          input logic [1:0] exp_st, input logic [19:0] exp_pa, input string tag);
        req_valid = 1'b1; req_vaddr = va; req_acc = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk(rsp_status == exp_st, {tag, " status"}, 32'(rsp_status), 32'(exp_st));
        chk(rsp_paddr == exp_pa, {tag, " paddr"}, 32'(rsp_paddr), 32'(exp_pa));
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_acc = '0;
        base_we = 1'b0; base_sel = '0; mt_we = 1'b0; mt_table = '0;
        mt_idx = '0; mt_valid = 1'b0; mt_rights = '0; mt_ppn = '0;
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: every table empty after reset
        for (int t = 0; t < 4; t++) begin
            set_base(t);
            lookup(32'h0000_3abc, 2'd1, 2'd1, 20'd0, "R1 empty table");
        end
        set_base(0);
        // R2: no response without a request
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2 idle", 32'(rsp_valid), 32'd0);

        // Program all tables.
        for (int t = 0; t < 4; t++)
            for (int i = 0; i < 32; i++)
                wr_entry(t, i, ent_valid(t, i), ent_rights(t, i), ent_ppn(t, i));

        // R3 R4 R5 R6 R7 R9: full sweep over tables, indices, access codes.
        for (int t = 0; t < 4; t++) begin
            set_base(t);
            for (int i = 0; i < 32; i++) begin
                for (int a = 0; a < 4; a++) begin
                    logic [11:0] off;
                    logic [1:0]  est;
                    logic [19:0] epa;
                    off = 12'((t * 97 + i * 13 + a * 5) & 12'hfff);
                    if (!ent_valid(t, i))                          est = 2'd1;
                    else if (!allowed(ent_rights(t, i), 2'(a)))    est = 2'd2;
                    else                                           est = 2'd0;
                    epa = (est == 2'd0) ? {ent_ppn(t, i), off} : 20'd0;
                    lookup({15'd0, 5'(i), off}, 2'(a), est, epa, "R3/R4/R5/R6/R7/R9 sweep");
                end
            end
        end
        // R2: strobe drops after the response cycle
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2 single strobe", 32'(rsp_valid), 32'd0);

        // R8: upper VPN bits set give a page fault even on a present entry.
        set_base(0);
        wr_entry(0, 2, 1'b1, 2'd3, 8'h5c);
        lookup(32'h0000_2123, 2'd1, 2'd0, {8'h5c, 12'h123}, "R8 in range");
        lookup(32'h0002_2123, 2'd1, 2'd1, 20'd0, "R8 bit17");
        lookup(32'h8000_2123, 2'd0, 2'd1, 20'd0, "R8 bit31");

        // R9: base switch in the same cycle as a request uses the old base.
        wr_entry(0, 1, 1'b1, 2'd3, 8'h11);
        wr_entry(2, 1, 1'b1, 2'd3, 8'h22);
        base_we = 1'b1; base_sel = 2'd2;
        lookup(32'h0000_1004, 2'd1, 2'd0, {8'h11, 12'h004}, "R9 same cycle");
        base_we = 1'b0;
        lookup(32'h0000_1004, 2'd1, 2'd0, {8'h22, 12'h004}, "R9 after switch");

        // R10: write and lookup of one entry in the same cycle.
        set_base(3);
        wr_entry(3, 4, 1'b0, 2'd0, 8'h00);
        mt_we = 1'b1; mt_table = 2'd3; mt_idx = 5'd4;
        mt_valid = 1'b1; mt_rights = 2'd3; mt_ppn = 8'ha5;
        lookup(32'h0000_4fff, 2'd2, 2'd1, 20'd0, "R10 old entry");
        mt_we = 1'b0;
        lookup(32'h0000_4fff, 2'd2, 2'd0, {8'ha5, 12'hfff}, "R10 new entry");

        // R7: invalid page with forbidden access still reports page fault.
        wr_entry(3, 6, 1'b0, 2'd2, 8'h77);
        lookup(32'h0000_6010, 2'd2, 2'd1, 20'd0, "R7 priority");
        // R11: the sweep above also confirmed no code 3
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule